// File: doc/BRIEF.md
# Low-Frequency Block Reconstructor (DC-only and 2x2)

This unit rebuilds pixels for transform blocks whose energy sits entirely in the lowest frequencies. In DC mode a single signed 16-bit coefficient becomes one pixel. The coefficient has a combined rounding and level-shift constant added to it, is divided by eight with an arithmetic shift, and is clamped to the 8-bit pixel range. In quad mode four signed 16-bit coefficients pass through a two-level add/subtract butterfly with no multipliers. Every sum saturates to 16 bits. Each result is divided by eight with round-half-up, has 128 added with saturation, and is clamped to 0..255.

Coefficients and a mode bit arrive on a valid/ready handshake. Results leave one cycle later on a valid/ready output as four 16-bit words, one per lane. Lane i occupies bits [16i+15:16i] of both the coefficient bus and the pixel bus. A single output register decouples the two sides. The input is ready whenever that register is empty or is being drained in the same cycle.

Top module: `lowfreq_idct`

## Requirements
- R1: In DC mode (in_mode = 0), lane 0 of the result equals (y0 + 1028) arithmetically shifted right by 3, where y0 is the lane-0 coefficient, whenever that value lies in 0..255.
- R2: In DC mode a negative shifted value yields 0 and a shifted value above 255 yields 255.
- R3: In quad mode (in_mode = 1), with a = y0+y2, b = y0-y2, c = y1+y3 and d = y1-y3, lanes 0..3 carry the reconstruction of a+c, a-c, b+d and b-d respectively. Lanes 0 and 1 form the top row and lanes 2 and 3 form the bottom row.
- R4: Every quad-mode add and subtract in both butterfly levels saturates to -32768..32767 before the next operation uses the result.
- R5: In quad mode each butterfly output v becomes (v + 4) arithmetically shifted right by 3, followed by a saturating add of 128.
- R6: Every output lane in quad mode is clamped to 0..255, and no output lane ever exceeds 255.
- R7: In DC mode lanes 1..3 of the output read zero, and coefficient lanes 1..3 have no effect.
- R8: The mode and coefficients are captured only on an accepted handshake. The output payload changes only when a new input is accepted.
- R9: An input accepted at a clock edge appears on out_pix with out_valid high immediately after that edge.
- R10: in_ready is high exactly when the output register is empty or out_ready is high. While out_valid is high and out_ready is low, out_valid and out_pix hold.
- R11: Synchronous active-high reset clears out_valid and out_pix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Coefficient set offered |
| in_ready | output | 1 | Unit can take a coefficient set this cycle |
| in_mode | input | 1 | 0 = DC only, 1 = 2x2 |
| in_coef | input | 64 | Four signed 16-bit coefficients, lane i at [16i+15:16i] |
| out_valid | output | 1 | Pixel set present |
| out_ready | input | 1 | Consumer takes the pixel set this cycle |
| out_pix | output | 64 | Four pixel words, lane i at [16i+15:16i], each 0..255 |

## Verification
The assertions assume that in_mode and in_coef are meaningful only in a cycle where in_valid is high. They also assume the consumer may drop out_ready at any time. On that basis they check output holding and ready behaviour against the handshake alone. The checker keeps its own copy of the accepted mode, so it can test DC-lane zeroing without any knowledge of the arithmetic. The stimulus changes inputs only at falling edges and holds in_valid high across a stall until the set is accepted, so every offered set is eventually taken.

// File: rtl/lfidct_pkg.sv
package lfidct_pkg;

    localparam int COEF_W  = 16;
    localparam int LANES   = 4;
    localparam int SHIFT   = 3;
    localparam int LEVEL   = 128;
    localparam int PIX_MAX = 255;
    localparam int BUS_W   = LANES * COEF_W;
    localparam int RND     = 1 << (SHIFT - 1);
    localparam int DC_BIAS = RND + (LEVEL << SHIFT);

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic        [COEF_W-1:0] pix_t;

    typedef enum logic {
        MODE_DC   = 1'b0,
        MODE_QUAD = 1'b1
    } blk_mode_e;

    typedef struct packed {
        coef_t lo_sum;
        coef_t lo_dif;
        coef_t hi_sum;
        coef_t hi_dif;
    } bfly_stage_t;

    function automatic coef_t sat_add(input coef_t a, input coef_t b);
        logic signed [COEF_W:0] s;
        s = {a[COEF_W-1], a} + {b[COEF_W-1], b};
        if (s[COEF_W] != s[COEF_W-1])
            sat_add = s[COEF_W] ? {1'b1, {(COEF_W-1){1'b0}}} : {1'b0, {(COEF_W-1){1'b1}}};
        else
            sat_add = s[COEF_W-1:0];
    endfunction

    function automatic coef_t sat_sub(input coef_t a, input coef_t b);
        logic signed [COEF_W:0] s;
        s = {a[COEF_W-1], a} - {b[COEF_W-1], b};
        if (s[COEF_W] != s[COEF_W-1])
            sat_sub = s[COEF_W] ? {1'b1, {(COEF_W-1){1'b0}}} : {1'b0, {(COEF_W-1){1'b1}}};
        else
            sat_sub = s[COEF_W-1:0];
    endfunction

    function automatic pix_t clamp_pix(input coef_t v);
        if (v < 0)
            clamp_pix = '0;
        else if (v > coef_t'(PIX_MAX))
            clamp_pix = pix_t'(PIX_MAX);
        else
            clamp_pix = v;
    endfunction

endpackage

// File: rtl/lfidct_dc_path.sv
module lfidct_dc_path
    import lfidct_pkg::*;
(
    input  coef_t y,
    output pix_t  pix
);
    localparam int EW = COEF_W + 2;
    localparam logic signed [EW-1:0] BIAS_V = EW'(DC_BIAS);

    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] sum;
    logic signed [EW-1:0] shifted;
    coef_t                narrow;

    always_comb begin
        ext     = {{2{y[COEF_W-1]}}, y};
        sum     = ext + BIAS_V;
        shifted = sum >>> SHIFT;
        narrow  = shifted[COEF_W-1:0];
        pix     = clamp_pix(narrow);
    end
endmodule

// File: rtl/lfidct_quad_bfly.sv
module lfidct_quad_bfly
    import lfidct_pkg::*;
(
    input  coef_t y [LANES],
    output coef_t x [LANES]
);
    bfly_stage_t st;

    always_comb begin
        st.lo_sum = sat_add(y[0], y[2]);
        st.lo_dif = sat_sub(y[0], y[2]);
        st.hi_sum = sat_add(y[1], y[3]);
        st.hi_dif = sat_sub(y[1], y[3]);
        x[0] = sat_add(st.lo_sum, st.hi_sum);
        x[1] = sat_sub(st.lo_sum, st.hi_sum);
        x[2] = sat_add(st.lo_dif, st.hi_dif);
        x[3] = sat_sub(st.lo_dif, st.hi_dif);
    end
endmodule

// File: rtl/lfidct_round_level.sv
module lfidct_round_level
    import lfidct_pkg::*;
(
    input  coef_t v,
    output pix_t  pix
);
    localparam int EW = COEF_W + 1;
    localparam logic signed [EW-1:0] RND_V = EW'(RND);

    logic signed [EW-1:0] wide;
    logic signed [EW-1:0] shifted;
    coef_t                scaled;
    coef_t                lifted;

    always_comb begin
        wide    = {v[COEF_W-1], v} + RND_V;
        shifted = wide >>> SHIFT;
        scaled  = shifted[COEF_W-1:0];
        lifted  = sat_add(scaled, coef_t'(LEVEL));
        pix     = clamp_pix(lifted);
    end
endmodule

// File: rtl/lfidct_out_reg.sv
module lfidct_out_reg #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          drain,
    input  logic [DW-1:0] d,
    output logic          can_load,
    output logic          valid,
    output logic [DW-1:0] q
);
    assign can_load = !valid || drain;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            q     <= '0;
        end else begin
            if (load) begin
                valid <= 1'b1;
                q     <= d;
            end else if (drain) begin
                valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lowfreq_idct.sv
module lowfreq_idct
    import lfidct_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_mode,
    input  logic [BUS_W-1:0] in_coef,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [BUS_W-1:0] out_pix
);
    coef_t      y      [LANES];
    coef_t      bx     [LANES];
    pix_t       qpix   [LANES];
    pix_t       dc_pix;
    blk_mode_e  mode;
    logic [BUS_W-1:0] next_pix;
    logic       accept;

    assign mode   = blk_mode_e'(in_mode);
    assign accept = in_valid && in_ready;

    lfidct_dc_path u_dc (
        .y   (y[0]),
        .pix (dc_pix)
    );

    lfidct_quad_bfly u_bfly (
        .y (y),
        .x (bx)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign y[i] = in_coef[i*COEF_W +: COEF_W];

        lfidct_round_level u_rl (
            .v   (bx[i]),
            .pix (qpix[i])
        );

        if (i == 0) begin : g_dc_lane
            assign next_pix[i*COEF_W +: COEF_W] = (mode == MODE_QUAD) ? qpix[i] : dc_pix;
        end else begin : g_ac_lane
            assign next_pix[i*COEF_W +: COEF_W] = (mode == MODE_QUAD) ? qpix[i] : '0;
        end
    end

    lfidct_out_reg #(.DW(BUS_W)) u_oreg (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .drain    (out_ready),
        .d        (next_pix),
        .can_load (in_ready),
        .valid    (out_valid),
        .q        (out_pix)
    );
endmodule

// File: rtl/lowfreq_idct_chk.sv
module lowfreq_idct_chk
    import lfidct_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_mode,
    input logic             out_valid,
    input logic             out_ready,
    input logic [BUS_W-1:0] out_pix
);
    logic mode_seen;
    logic hi_any;

    always_ff @(posedge clk) begin
        if (rst)
            mode_seen <= 1'b0;
        else if (in_valid && in_ready)
            mode_seen <= in_mode;
    end

    always_comb begin
        hi_any = 1'b0;
        for (int i = 0; i < LANES; i++)
            hi_any = hi_any | (|out_pix[i*COEF_W+8 +: COEF_W-8]);
    end

    assert_pix_range_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !hi_any);

    assert_dc_lanes_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mode_seen == 1'b0) |-> (out_pix[BUS_W-1:COEF_W] == '0));

    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

    assert_stall_block_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    assert_payload_fixed_R8: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> $stable(out_pix));
endmodule

bind lowfreq_idct lowfreq_idct_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_mode   (in_mode),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix   (out_pix)
);

// File: tb/lowfreq_idct_tb.sv
module lowfreq_idct_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_mode = 1'b0;
    logic [63:0] in_coef = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_pix;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lowfreq_idct u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_coef(in_coef), .out_valid(out_valid),
        .out_ready(out_ready), .out_pix(out_pix)
    );

    function automatic int s16(input int v);
        return (v > 32767) ? 32767 : ((v < -32768) ? -32768 : v);
    endfunction

    function automatic int pixc(input int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction

    function automatic int ref_dc(input int y);
        return pixc((y + 1028) >>> 3);
    endfunction

    function automatic int ref_lane(input int v);
        return pixc(s16(((v + 4) >>> 3) + 128));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic offer(input bit mode, input int y0, input int y1, input int y2, input int y3);
        @(negedge clk);
        in_valid = 1'b1;
        in_mode  = mode;
        in_coef  = {16'(y3), 16'(y2), 16'(y1), 16'(y0)};
    endtask

    task automatic expect_out(input string req, input bit mode,
                              input int y0, input int y1, input int y2, input int y3);
        int e [4];
        if (mode) begin
            int a, b, c, d;
            a = s16(y0 + y2); b = s16(y0 - y2);
            c = s16(y1 + y3); d = s16(y1 - y3);
            e[0] = ref_lane(s16(a + c)); e[1] = ref_lane(s16(a - c));
            e[2] = ref_lane(s16(b + d)); e[3] = ref_lane(s16(b - d));
        end else begin
            e[0] = ref_dc(y0); e[1] = 0; e[2] = 0; e[3] = 0;
        end
        chk({req, " valid"}, int'(out_valid), 1);
        for (int i = 0; i < 4; i++)
            chk($sformatf("%s lane%0d", req, i), int'(out_pix[i*16 +: 16]), e[i]);
    endtask

    task automatic run_one(input string req, input bit mode,
                           input int y0, input int y1, input int y2, input int y3);
        offer(mode, y0, y1, y2, y3);
        @(posedge clk); #1;
        in_valid = 1'b0;
        expect_out(req, mode, y0, y1, y2, y3);
    endtask

    task automatic test_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R11 out_valid", int'(out_valid), 0);
        chk("R11 out_pix", int'(out_pix != 0), 0);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R10 ready after reset", int'(in_ready), 1);
    endtask

    task automatic test_dc_values();
        run_one("R1 zero", 0, 0, 0, 0, 0);
        run_one("R1 plus5", 0, 5, 0, 0, 0);
        run_one("R1 minus1", 0, -1, 0, 0, 0);
        run_one("R1 minus5", 0, -5, 0, 0, 0);
        run_one("R1 top", 0, 1016, 0, 0, 0);
        run_one("R1 bottom", 0, -1024, 0, 0, 0);
    endtask

    task automatic test_dc_clamp();
        run_one("R2 low edge", 0, -1029, 0, 0, 0);
        run_one("R2 high edge", 0, 1020, 0, 0, 0);
        run_one("R2 most negative", 0, -32768, 0, 0, 0);
        run_one("R2 most positive", 0, 32767, 0, 0, 0);
    endtask

    task automatic test_dc_ignore();
        run_one("R7 busy upper lanes", 0, 40, 1234, -999, 32767);
    endtask

    task automatic test_quad_basic();
        run_one("R3 mixed", 1, 100, 40, 20, 8);
        run_one("R3 signs", 1, -64, 200, 32, -48);
    endtask

    task automatic test_quad_round();
        run_one("R5 three", 1, 3, 0, 0, 0);
        run_one("R5 four", 1, 4, 0, 0, 0);
        run_one("R5 minus4", 1, -4, 0, 0, 0);
        run_one("R5 minus5", 1, -5, 0, 0, 0);
    endtask

    task automatic test_quad_sat();
        run_one("R4 first level", 1, 30000, -32700, 30000, 0);
        run_one("R4 both levels", 1, 32767, 32767, 32767, -32768);
    endtask

    task automatic test_quad_clamp();
        run_one("R6 negative", 1, -2000, 0, 0, 0);
        run_one("R6 positive", 1, 2000, 500, 0, 0);
    endtask

    task automatic test_mode_capture();
        logic [63:0] held;
        run_one("R8 quad sent", 1, 80, 16, 8, 0);
        held = out_pix;
        @(negedge clk);
        in_mode = 1'b0;
        in_coef = 64'h1234_5678_9abc_def0;
        @(posedge clk); #1;
        chk("R8 drained", int'(out_valid), 0);
        chk("R8 payload kept", int'(out_pix == held), 1);
    endtask

    task automatic test_stall();
        logic [63:0] first;
        out_ready = 1'b0;
        run_one("R10 first", 1, 48, 24, 16, 8);
        first = out_pix;
        offer(0, 200, 0, 0, 0);
        #1;
        chk("R10 blocked", int'(in_ready), 0);
        @(posedge clk); #1;
        chk("R10 hold valid", int'(out_valid), 1);
        chk("R10 hold data", int'(out_pix == first), 1);
        @(negedge clk);
        out_ready = 1'b1;
        #1;
        chk("R10 ready on drain", int'(in_ready), 1);
        @(posedge clk); #1;
        in_valid = 1'b0;
        expect_out("R9 second after stall", 0, 200, 0, 0, 0);
    endtask

    initial begin
        test_reset();
        test_dc_values();
        test_dc_clamp();
        test_dc_ignore();
        test_quad_basic();
        test_quad_round();
        test_quad_sat();
        test_quad_clamp();
        test_mode_capture();
        test_stall();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule